// File: doc/BRIEF.md
# Pixel Format Decoder and Blender

This block sits between the video memory fetch logic and the analogue output stage of a display pipeline. On every dot clock on which a pixel is offered, it takes the 16-bit memory word that holds that pixel and turns it into one 24-bit RGB value. The colour mode sets how the word is read: packed 4-bit or 8-bit palette indices, 15-bit or 16-bit direct colour, or luma/chroma 4:2:2 samples. Palette indices look up a shared 256-entry colour table. The same table can also remap each component of a direct-colour pixel.

The decoded pixel is then mixed with a second layer using a 6-bit level. The second layer is either a live 18-bit external RGB input, widened to 24 bits, or a flat border colour. The fetch logic drives a start-of-line strobe so that the block can tell which pixel of a word, or which half of a chroma pair, it is handling. The result leaves the block a fixed number of cycles later, with a matching valid flag.

Top module: `pix_decode_blend`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 3 clock cycles, and `out_rgb` carries the pixel offered 3 cycles earlier. While `rst` is high, `out_valid` and `out_rgb` are 0 after the next clock edge.
- R2: A per-pixel phase count restarts at 0 on a valid pixel with `line_start` high and advances by one, modulo 4, on each valid pixel. Reset clears it to 0, and invalid cycles leave it unchanged.
- R3: With `mode` = 0 (4-bit palette), phase p mod 4 selects nibble `mem_word[15-4p -: 4]`, so phase 0 takes the most significant nibble. That nibble indexes the table. The entry is read as R in [15:11], G in [10:5] and B in [4:0], and each field is widened to 8 bits by appending its own top bits.
- R4: With `mode` = 1 (8-bit palette), an even phase takes the index from `mem_word[15:8]` and an odd phase takes it from `mem_word[7:0]`. The entry is decoded as in R3.
- R5: With `mode` = 3, the word is R[15:11], G[10:5], B[4:0]. With `mode` = 2, the word is R[14:10], G[9:5], B[4:0], and bit 15 has no effect. Each field is widened by appending its top bits.
- R6: With `mode` 2 or 3 and `clut_direct_en` high, each widened component from R5 indexes the table separately, and bits [7:0] of that entry become the output component.
- R7: With `mode` = 4, `mem_word[15:8]` is luma Y. On an even phase `mem_word[7:0]` is Cb, and on an odd phase it is Cr. Both pixels of a pair use the pair's Cb and Cr, and a pair must arrive on consecutive valid cycles. The conversion is: T=298(Y-16), R=(T+409(Cr-128)+128)>>8, G=(T-208(Cr-128)-100(Cb-128)+128)>>8, B=(T+516(Cb-128)+128)>>8. Each result is clamped to 0..255.
- R8: Each output component is (a*P + (63-a)*Q + 31) div 63, where a is `blend_lvl`, P is the decoded pixel and Q is the second layer. a=63 gives P, and a=0 gives Q.
- R9: With `layer_sel` = 0, Q is `ext_rgb` (R[17:12], G[11:6], B[5:0]), with each 6-bit field c widened to {c, c[5:4]}. With `layer_sel` = 1, Q is `border_rgb`. The 24-bit layout is R[23:16], G[15:8], B[7:0] for `border_rgb` and for `out_rgb`.
- R10: A table write on a cycle takes effect for a pixel offered on that same cycle or on any later one.
- R11: `mode` values 5, 6 and 7 decode to black (P = 0) before the mix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A pixel is offered this cycle |
| line_start | input | 1 | This valid pixel is phase 0 |
| mem_word | input | 16 | Memory word holding the pixel |
| mode | input | 3 | Colour mode select |
| clut_direct_en | input | 1 | Route direct-colour components through the table |
| clut_we | input | 1 | Colour table write enable |
| clut_waddr | input | 8 | Colour table write address |
| clut_wdata | input | 16 | Colour table write data |
| ext_rgb | input | 18 | External pixel, 6 bits per component |
| layer_sel | input | 1 | Second layer: 0 external, 1 border |
| border_rgb | input | 24 | Border colour |
| blend_lvl | input | 6 | Mix level a, 0..63 |
| out_rgb | output | 24 | Mixed pixel |
| out_valid | output | 1 | out_rgb is valid |

## Verification
Every decoded and mixed result appears at the ports three rising edges after the falling edge on which the bench drove its stimulus. For that reason the bench stores each expected value in a slot indexed by cycle, and it reads the slot back three steps later, just before it drives the next stimulus. For a luma/chroma pair, the result of the even pixel depends on the Cr carried by the following word. The bench therefore completes the even pixel's slot when it drives the odd word, which is still two cycles before that slot is compared. A table write and a pixel that reads the same entry are driven in the same step. The reset checks sample one edge after `rst` rises.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

  localparam int COMP_W = 8;
  localparam int PIX_W  = 3 * COMP_W;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    PM_PAL4  = 3'd0,
    PM_PAL8  = 3'd1,
    PM_RGB15 = 3'd2,
    PM_RGB16 = 3'd3,
    PM_YCC   = 3'd4
  } pix_mode_e;

  typedef enum logic [2:0] {
    SRC_PAL,
    SRC_LUT,
    SRC_DIR,
    SRC_YCC,
    SRC_BLACK
  } pix_src_e;

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [PIX_W-1:0] rgb565_to_24(input logic [15:0] e);
    return {widen5(e[15:11]), widen6(e[10:5]), widen5(e[4:0])};
  endfunction

endpackage

// File: rtl/pdb_clut_bank.sv
module pdb_clut_bank #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pdb_unpack.sv
module pdb_unpack
  import pdb_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        mode,
  input  logic [1:0]        phase,
  output logic [7:0]        pal_idx,
  output logic [PIX_W-1:0]  direct,
  output logic [7:0]        luma,
  output logic [7:0]        chroma,
  output logic              odd
);

  always_comb begin
    pal_idx = 8'd0;
    direct  = '0;
    case (pix_mode_e'(mode))
      PM_PAL4: begin
        case (phase)
          2'd0:    pal_idx = {4'd0, word[15:12]};
          2'd1:    pal_idx = {4'd0, word[11:8]};
          2'd2:    pal_idx = {4'd0, word[7:4]};
          default: pal_idx = {4'd0, word[3:0]};
        endcase
      end
      PM_PAL8:  pal_idx = phase[0] ? word[7:0] : word[15:8];
      PM_RGB16: direct  = {widen5(word[15:11]), widen6(word[10:5]), widen5(word[4:0])};
      PM_RGB15: direct  = {widen5(word[14:10]), widen5(word[9:5]), widen5(word[4:0])};
      default: ;
    endcase
  end

  assign luma   = word[15:8];
  assign chroma = word[7:0];
  assign odd    = phase[0];

endmodule

// File: rtl/pdb_ycc2rgb.sv
module pdb_ycc2rgb
  import pdb_pkg::*;
(
  input  logic [7:0]       y,
  input  logic [7:0]       cb,
  input  logic [7:0]       cr,
  output logic [PIX_W-1:0] rgb
);

  logic signed [19:0] yv, cbv, crv, yt, rs, gs, bs;

  function automatic logic [7:0] clamp8(input logic signed [19:0] x);
    if (x[19])            return 8'd0;
    else if (|x[18:16])   return 8'd255;
    else                  return x[15:8];
  endfunction

  always_comb begin
    yv  = $signed({12'd0, y})  - 20'sd16;
    cbv = $signed({12'd0, cb}) - 20'sd128;
    crv = $signed({12'd0, cr}) - 20'sd128;
    yt  = 20'sd298 * yv;
    rs  = yt + 20'sd409 * crv + 20'sd128;
    gs  = yt - 20'sd208 * crv - 20'sd100 * cbv + 20'sd128;
    bs  = yt + 20'sd516 * cbv + 20'sd128;
    rgb = {clamp8(rs), clamp8(gs), clamp8(bs)};
  end

endmodule

// File: rtl/pdb_mix.sv
module pdb_mix #(
  parameter int LVL_W = 6,
  localparam int MAXL = (1 << LVL_W) - 1,
  localparam int SUM_W = 8 + LVL_W + 1
) (
  input  logic [LVL_W-1:0] lvl,
  input  logic [7:0]       fg,
  input  logic [7:0]       bg,
  output logic [7:0]       mixed
);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(lvl) * SUM_W'(fg)
        + (SUM_W'(MAXL) - SUM_W'(lvl)) * SUM_W'(bg)
        + SUM_W'(MAXL / 2);
    mixed = 8'(sum / SUM_W'(MAXL));
  end

endmodule

// File: rtl/pix_decode_blend.sv
module pix_decode_blend
  import pdb_pkg::*;
#(
  parameter int CLUT_DEPTH = 256,
  parameter int ALPHA_W    = 6,
  parameter int EXT_W      = 6,
  localparam int AW        = $clog2(CLUT_DEPTH),
  localparam int ALPHA_MAX = (1 << ALPHA_W) - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 line_start,
  input  logic [WORD_W-1:0]    mem_word,
  input  logic [2:0]           mode,
  input  logic                 clut_direct_en,
  input  logic                 clut_we,
  input  logic [AW-1:0]        clut_waddr,
  input  logic [WORD_W-1:0]    clut_wdata,
  input  logic [3*EXT_W-1:0]   ext_rgb,
  input  logic                 layer_sel,
  input  logic [PIX_W-1:0]     border_rgb,
  input  logic [ALPHA_W-1:0]   blend_lvl,
  output logic [PIX_W-1:0]     out_rgb,
  output logic                 out_valid
);

  // ---------------- stage 1: capture ----------------
  logic [1:0]          phase_cnt, phase_eff;
  logic                s1_valid, s1_cdir;
  logic [WORD_W-1:0]   s1_word;
  logic [2:0]          s1_mode;
  logic [1:0]          s1_phase;
  logic [ALPHA_W-1:0]  s1_alpha;
  logic [PIX_W-1:0]    s1_layer, ext_wide;

  for (genvar c = 0; c < 3; c++) begin : g_ext
    assign ext_wide[c*COMP_W +: COMP_W] =
      {ext_rgb[c*EXT_W +: EXT_W], ext_rgb[c*EXT_W + EXT_W - 1 -: (COMP_W - EXT_W)]};
  end

  assign phase_eff = line_start ? 2'd0 : phase_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      phase_cnt <= 2'd0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) phase_cnt <= phase_eff + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    s1_word  <= mem_word;
    s1_mode  <= mode;
    s1_phase <= phase_eff;
    s1_cdir  <= clut_direct_en;
    s1_alpha <= blend_lvl;
    s1_layer <= layer_sel ? border_rgb : ext_wide;
  end

  // ---------------- stage 1 -> 2: decode ----------------
  logic [7:0]       pal_idx, luma, chroma, prev_c, cb_sel, cr_sel;
  logic [PIX_W-1:0] dir_rgb, ycc_rgb;
  logic             odd;
  pix_src_e         src;

  pdb_unpack u_unpack (
    .word    (s1_word),
    .mode    (s1_mode),
    .phase   (s1_phase),
    .pal_idx (pal_idx),
    .direct  (dir_rgb),
    .luma    (luma),
    .chroma  (chroma),
    .odd     (odd)
  );

  // Even pixel borrows Cr from the odd word now at the input; odd pixel
  // reuses the Cb its even partner carried.
  assign cb_sel = odd ? prev_c : chroma;
  assign cr_sel = odd ? chroma : mem_word[7:0];

  always_ff @(posedge clk) begin
    if (s1_valid) prev_c <= chroma;
  end

  pdb_ycc2rgb u_ycc (
    .y   (luma),
    .cb  (cb_sel),
    .cr  (cr_sel),
    .rgb (ycc_rgb)
  );

  always_comb begin
    case (pix_mode_e'(s1_mode))
      PM_PAL4, PM_PAL8:   src = SRC_PAL;
      PM_RGB15, PM_RGB16: src = s1_cdir ? SRC_LUT : SRC_DIR;
      PM_YCC:             src = SRC_YCC;
      default:            src = SRC_BLACK;
    endcase
  end

  // Three table copies give one read per component in a single cycle.
  logic [AW-1:0]     rd_addr [3];
  logic [WORD_W-1:0] lut0_q;
  logic [7:0]        lut_q [3];

  assign rd_addr[0] = (src == SRC_PAL) ? AW'(pal_idx) : AW'(dir_rgb[23:16]);
  assign rd_addr[1] = AW'(dir_rgb[15:8]);
  assign rd_addr[2] = AW'(dir_rgb[7:0]);

  for (genvar b = 0; b < 3; b++) begin : g_bank
    if (b == 0) begin : g_full
      pdb_clut_bank #(.DEPTH(CLUT_DEPTH), .DATA_W(WORD_W)) u_bank (
        .clk   (clk),
        .we    (clut_we),
        .waddr (clut_waddr),
        .wdata (clut_wdata),
        .raddr (rd_addr[b]),
        .rdata (lut0_q)
      );
      assign lut_q[b] = lut0_q[7:0];
    end else begin : g_byte
      pdb_clut_bank #(.DEPTH(CLUT_DEPTH), .DATA_W(COMP_W)) u_bank (
        .clk   (clk),
        .we    (clut_we),
        .waddr (clut_waddr),
        .wdata (clut_wdata[7:0]),
        .raddr (rd_addr[b]),
        .rdata (lut_q[b])
      );
    end
  end

  logic               s2_valid;
  pix_src_e           s2_src;
  logic [PIX_W-1:0]   s2_dir, s2_ycc, s2_layer, s2_pix, mix_rgb;
  logic [ALPHA_W-1:0] s2_alpha;

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    s2_src   <= src;
    s2_dir   <= dir_rgb;
    s2_ycc   <= ycc_rgb;
    s2_alpha <= s1_alpha;
    s2_layer <= s1_layer;
  end

  always_comb begin
    case (s2_src)
      SRC_PAL: s2_pix = rgb565_to_24(lut0_q);
      SRC_LUT: s2_pix = {lut_q[0], lut_q[1], lut_q[2]};
      SRC_DIR: s2_pix = s2_dir;
      SRC_YCC: s2_pix = s2_ycc;
      default: s2_pix = '0;
    endcase
  end

  // ---------------- stage 3: mix ----------------
  for (genvar c = 0; c < 3; c++) begin : g_mix
    pdb_mix #(.LVL_W(ALPHA_W)) u_mix (
      .lvl   (s2_alpha),
      .fg    (s2_pix[c*COMP_W +: COMP_W]),
      .bg    (s2_layer[c*COMP_W +: COMP_W]),
      .mixed (mix_rgb[c*COMP_W +: COMP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= s2_valid;
      out_rgb   <= mix_rgb;
    end
  end

  // ---------------- assertions ----------------
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 3)  age <= age + 2'd1;
  end

  p_valid_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_phase_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && line_start) |=> (phase_cnt == 2'd1));

  p_chroma_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == PM_YCC && !s1_phase[0]) |-> in_valid);

  p_full_level_r8: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_alpha == ALPHA_W'(ALPHA_MAX)) |=> (out_rgb == $past(s2_pix)));

  p_zero_level_r8: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_alpha == '0) |=> (out_rgb == $past(s2_layer)));

  p_black_mode_r11: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_src == SRC_BLACK && s2_alpha == ALPHA_W'(ALPHA_MAX)) |=> (out_rgb == '0));

endmodule

// File: tb/pix_decode_blend_tb_top.sv
module pix_decode_blend_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, in_valid, line_start, clut_direct_en, clut_we, layer_sel;
  logic [15:0] mem_word, clut_wdata;
  logic [2:0]  mode;
  logic [7:0]  clut_waddr;
  logic [17:0] ext_rgb;
  logic [23:0] border_rgb, out_rgb;
  logic [5:0]  blend_lvl;
  logic        out_valid;

  pix_decode_blend dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .line_start(line_start),
    .mem_word(mem_word), .mode(mode), .clut_direct_en(clut_direct_en),
    .clut_we(clut_we), .clut_waddr(clut_waddr), .clut_wdata(clut_wdata),
    .ext_rgb(ext_rgb), .layer_sel(layer_sel), .border_rgb(border_rgb),
    .blend_lvl(blend_lvl), .out_rgb(out_rgb), .out_valid(out_valid)
  );

  typedef struct packed {
    logic        v;
    logic        ls;
    logic [2:0]  md;
    logic        cd;
    logic [15:0] w;
    logic [5:0]  a;
    logic        lsel;
    logic [17:0] ext;
    logic [23:0] bd;
  } vec_t;

  localparam vec_t IDLE = '{1'b0, 1'b0, 3'd0, 1'b0, 16'h0, 6'd0, 1'b0, 18'h0, 24'h0};
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 3'd0, 1'b0, 16'h1234, 6'd63, 1'b0, 18'h0,     24'h0},      // R3 nibble 1
    '{1'b1, 1'b0, 3'd0, 1'b0, 16'h1234, 6'd63, 1'b0, 18'h0,     24'h0},      // R3 nibble 2
    '{1'b1, 1'b0, 3'd0, 1'b0, 16'h1234, 6'd63, 1'b0, 18'h0,     24'h0},      // R3 nibble 3
    '{1'b1, 1'b0, 3'd0, 1'b0, 16'h1234, 6'd20, 1'b0, 18'h3F03F, 24'h0},      // R3 R8 R9 ext
    '{1'b1, 1'b1, 3'd1, 1'b0, 16'hA55A, 6'd63, 1'b0, 18'h0,     24'h0},      // R4 high byte
    '{1'b1, 1'b0, 3'd1, 1'b0, 16'hA55A, 6'd63, 1'b0, 18'h0,     24'h0},      // R4 low byte
    '{1'b0, 1'b0, 3'd1, 1'b0, 16'hFFFF, 6'd63, 1'b0, 18'h0,     24'h0},      // R1 bubble
    '{1'b1, 1'b1, 3'd3, 1'b0, 16'hF81F, 6'd63, 1'b0, 18'h0,     24'h0},      // R5 565
    '{1'b1, 1'b0, 3'd3, 1'b0, 16'h07E0, 6'd0,  1'b1, 18'h0,     24'h123456}, // R8 R9 border
    '{1'b1, 1'b0, 3'd2, 1'b0, 16'h7FFF, 6'd63, 1'b0, 18'h0,     24'h0},      // R5 555
    '{1'b1, 1'b0, 3'd2, 1'b0, 16'hFFFF, 6'd63, 1'b0, 18'h0,     24'h0},      // R5 bit 15 ignored
    '{1'b1, 1'b0, 3'd2, 1'b0, 16'h0421, 6'd31, 1'b0, 18'h2A5C3, 24'h0},      // R8 mid level
    '{1'b1, 1'b0, 3'd3, 1'b1, 16'h8410, 6'd63, 1'b0, 18'h0,     24'h0},      // R6
    '{1'b1, 1'b0, 3'd2, 1'b1, 16'h2D6B, 6'd45, 1'b1, 18'h0,     24'h00FF80}, // R6 R8
    '{1'b1, 1'b1, 3'd4, 1'b0, {8'd235, 8'd128}, 6'd63, 1'b0, 18'h0, 24'h0},  // R7 white
    '{1'b1, 1'b0, 3'd4, 1'b0, {8'd235, 8'd128}, 6'd63, 1'b0, 18'h0, 24'h0},  // R7
    '{1'b1, 1'b0, 3'd4, 1'b0, {8'd81,  8'd90},  6'd63, 1'b0, 18'h0, 24'h0},  // R7 clamp
    '{1'b1, 1'b0, 3'd4, 1'b0, {8'd145, 8'd240}, 6'd10, 1'b1, 18'h0, 24'h204060}, // R7 R8
    '{1'b1, 1'b0, 3'd5, 1'b0, 16'hFFFF, 6'd63, 1'b0, 18'h0,     24'h0},      // R11
    '{1'b1, 1'b0, 3'd7, 1'b0, 16'h1234, 6'd63, 1'b0, 18'h0,     24'h0},      // R11
    '{1'b1, 1'b1, 3'd1, 1'b0, 16'h0000, 6'd40, 1'b1, 18'h0,     24'hAB10F0}  // R4 R8
  };

  int          n_chk, n_fail, cyc;
  logic [23:0] exp_rgb [8];
  logic        exp_v   [8];
  string       exp_tag [8];
  logic [15:0] clut_m  [256];
  logic [1:0]  mphase;
  int          pend_y, pend_cb, pend_slot, pend_a;
  logic [23:0] pend_q;
  bit          done;

  function automatic logic [7:0] w5(input logic [4:0] v); return {v, v[4:2]}; endfunction
  function automatic logic [7:0] w6(input logic [5:0] v); return {v, v[5:4]}; endfunction

  function automatic logic [7:0] sat(input int x);
    if (x < 0) return 8'd0;
    if (x / 256 > 255) return 8'd255;
    return 8'(x / 256);
  endfunction

  function automatic logic [23:0] ycc(input int y, input int cb, input int cr);
    int t;
    t = 298 * (y - 16);
    return {sat(t + 409 * (cr - 128) + 128),
            sat(t - 208 * (cr - 128) - 100 * (cb - 128) + 128),
            sat(t + 516 * (cb - 128) + 128)};
  endfunction

  function automatic logic [23:0] mix(input int a, input logic [23:0] p, input logic [23:0] q);
    logic [23:0] r;
    for (int c = 0; c < 3; c++)
      r[c*8 +: 8] = 8'((a * int'(p[c*8 +: 8]) + (63 - a) * int'(q[c*8 +: 8]) + 31) / 63);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(input vec_t v, input logic we = 1'b0,
                      input logic [7:0] wa = 8'd0, input logic [15:0] wd = 16'd0);
    int slot;
    logic [1:0] ph;
    logic [23:0] p, q;
    logic [15:0] w;
    string tag;
    @(negedge clk);
    if (cyc >= 3) begin
      slot = (cyc - 3) % 8;
      chk({"R1 valid ", exp_tag[slot]}, 32'(out_valid), 32'(exp_v[slot]));
      if (exp_v[slot]) chk(exp_tag[slot], 32'(out_rgb), 32'(exp_rgb[slot]));
    end
    in_valid = v.v; line_start = v.ls; mode = v.md; clut_direct_en = v.cd;
    mem_word = v.w; blend_lvl = v.a; layer_sel = v.lsel; ext_rgb = v.ext;
    border_rgb = v.bd; clut_we = we; clut_waddr = wa; clut_wdata = wd;
    if (we) clut_m[wa] = wd;
    slot = cyc % 8;
    exp_v[slot] = v.v;
    exp_tag[slot] = "R1";
    if (v.v) begin
      w = v.w;
      ph = v.ls ? 2'd0 : mphase;
      mphase = ph + 2'd1;
      q = v.lsel ? v.bd : {w6(v.ext[17:12]), w6(v.ext[11:6]), w6(v.ext[5:0])};
      p = 24'd0;
      case (v.md)
        3'd0: begin
          w = clut_m[{4'd0, v.w[15 - 4*int'(ph) -: 4]}];
          p = {w5(w[15:11]), w6(w[10:5]), w5(w[4:0])}; tag = "R3";
        end
        3'd1: begin
          w = clut_m[ph[0] ? v.w[7:0] : v.w[15:8]];
          p = {w5(w[15:11]), w6(w[10:5]), w5(w[4:0])}; tag = "R4";
        end
        3'd2, 3'd3: begin
          if (v.md == 3'd3) p = {w5(w[15:11]), w6(w[10:5]), w5(w[4:0])};
          else              p = {w5(w[14:10]), w5(w[9:5]), w5(w[4:0])};
          tag = "R5";
          if (v.cd) begin
            p = {clut_m[p[23:16]][7:0], clut_m[p[15:8]][7:0], clut_m[p[7:0]][7:0]};
            tag = "R6";
          end
        end
        3'd4: begin
          tag = "R7";
          if (!ph[0]) begin
            pend_y = int'(w[15:8]); pend_cb = int'(w[7:0]);
            pend_slot = slot; pend_a = int'(v.a); pend_q = q;
          end else begin
            exp_rgb[pend_slot] = mix(pend_a, ycc(pend_y, pend_cb, int'(w[7:0])), pend_q);
            p = ycc(int'(w[15:8]), pend_cb, int'(w[7:0]));
          end
        end
        default: begin p = 24'd0; tag = "R11"; end
      endcase
      if (v.a != 6'd63) tag = {tag, v.lsel ? " R8 R9 border" : " R8 R9 ext"};
      exp_tag[slot] = tag;
      exp_rgb[slot] = mix(int'(v.a), p, q);
      if (v.md == 3'd4 && !ph[0]) exp_rgb[slot] = 24'hx;
    end
    cyc++;
  endtask

  task automatic model_reset();
    cyc = 0; mphase = 2'd0;
    for (int i = 0; i < 8; i++) begin exp_v[i] = 1'b0; exp_tag[i] = "R1"; end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst = 1'b1; in_valid = 0; line_start = 0; mode = 0; clut_direct_en = 0;
    clut_we = 0; clut_waddr = 0; clut_wdata = 0; mem_word = 0; ext_rgb = 0;
    layer_sel = 0; border_rgb = 0; blend_lvl = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    chk("R1 reset rgb", 32'(out_rgb), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < 256; i++)
      step(IDLE, 1'b1, 8'(i), 16'((i * 40503) ^ 16'h5A3C));

    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R10: write entry 7 in the same step as a pixel that reads it
    step('{1'b1, 1'b1, 3'd1, 1'b0, 16'h0700, 6'd63, 1'b0, 18'h0, 24'h0}, 1'b1, 8'd7, 16'hF81F);
    step('{1'b1, 1'b0, 3'd1, 1'b0, 16'h0007, 6'd63, 1'b0, 18'h0, 24'h0}, 1'b1, 8'd7, 16'h07E0);
    repeat (4) step(IDLE);

    // R1 / R2: reset in the middle of a stream
    step('{1'b1, 1'b1, 3'd0, 1'b0, 16'h9999, 6'd63, 1'b0, 18'h0, 24'h0});
    step('{1'b1, 1'b0, 3'd0, 1'b0, 16'h9999, 6'd63, 1'b0, 18'h0, 24'h0});
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R1 midstream reset valid", 32'(out_valid), 32'd0);
    chk("R1 midstream reset rgb", 32'(out_rgb), 32'd0);
    rst = 1'b0;
    model_reset();
    // R2: phase restarts at 0 after reset without line_start
    step('{1'b1, 1'b0, 3'd0, 1'b0, 16'hABCD, 6'd63, 1'b0, 18'h0, 24'h0});
    step('{1'b1, 1'b0, 3'd0, 1'b0, 16'hABCD, 6'd63, 1'b0, 18'h0, 24'h0});
    step(IDLE);
    step('{1'b1, 1'b0, 3'd0, 1'b0, 16'hABCD, 6'd63, 1'b0, 18'h0, 24'h0});
    repeat (4) step(IDLE);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule